// File: doc/BRIEF.md
# Integer Execute Unit with Signed-Overflow Trap

This block is the integer execute stage of a classic load/store RISC pipeline. It has no clock. It takes a 5-bit operation select, two register operands and a 16-bit immediate. In the same cycle it returns a 32-bit result, a register write-enable and an overflow-trap flag. The unit is the register-first operand `srcA`. `srcB` is the second register operand. It is also the value that every shift moves.

The operations are:
- add and subtract, each in a trapping and a wrapping form;
- add-immediate, in a trapping and a wrapping form;
- the four bitwise logic functions on two registers;
- three logic operations with an immediate;
- left, logical-right and arithmetic-right shifts, with the amount taken either from a register or from a separate 5-bit field;
- load-upper-immediate.

The pipeline control uses `wrEn` to gate the register-file write. It uses `ovfTrap` to start exception entry.

Top module: `int_exec_unit`

## Requirements
- R1: For the trapping codes 0 (add), 2 (subtract srcA-srcB) and 4 (add sign-extended immediate), a signed two's-complement overflow drives `ovfTrap`=1 and `wrEn`=0 in the same cycle.
- R2: For codes 0, 2 and 4 without overflow, `wrEn`=1, `ovfTrap`=0, and `result` holds the exact sum or difference.
- R3: Codes 1 (add), 3 (subtract) and 5 (add immediate) return the sum or difference modulo 2^32 with `wrEn`=1, and they never assert `ovfTrap`.
- R4: Codes 4 and 5 sign-extend `imm16`, so 0x8000 adds -32768 and 0x7FFF adds +32767.
- R5: Codes 10 (AND), 11 (OR) and 12 (XOR) combine `srcA` with `imm16` zero-extended, so bits 31:16 of the immediate operand are always 0.
- R6: Codes 6, 7, 8 and 9 return `srcA` AND, OR, XOR and NOR `srcB` respectively. NOR is the bitwise inverse of (`srcA` OR `srcB`).
- R7: Codes 13 (left), 14 (logical right) and 15 (arithmetic right) shift `srcB` by `srcA[4:0]`. The higher bits of `srcA` are ignored.
- R8: Codes 16 (left), 17 (logical right) and 18 (arithmetic right) shift `srcB` by `shamt` (0..31). An amount of 0 returns `srcB` unchanged.
- R9: An arithmetic right shift fills with bit 31 of `srcB`, and a logical right shift fills with zeros. A left shift that pushes set bits out of bit 31 keeps `wrEn`=1 and `ovfTrap`=0.
- R10: Code 19 returns `imm16` in bits 31:16 and zeros in bits 15:0, with `wrEn`=1.
- R11: Codes 20 to 31 are unused. They give `result`=0, `wrEn`=0 and `ovfTrap`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opSel | input | 5 | Operation select code |
| srcA | input | 32 | First register operand; shift amount source for codes 13 to 15 |
| srcB | input | 32 | Second register operand; value that is shifted |
| imm16 | input | 16 | Immediate field |
| shamt | input | 5 | Shift amount for codes 16 to 18 |
| result | output | 32 | Operation result |
| wrEn | output | 1 | Destination register write-enable |
| ovfTrap | output | 1 | Signed-overflow exception request |

## Verification
The checker watches the output rules that hold for any operands:
- a trap never occurs together with a write;
- only the three trapping codes may trap;
- every legal code writes unless it traps;
- load-upper always has a clear low half, and its upper half equals the immediate;
- the AND-immediate upper half is always zero;
- unused codes stay silent.

Only the bench's scenarios can show that the numerical values are right:
- the exact overflow boundaries (0x7FFFFFFF+1, 0 minus 0x80000000, the -32768 immediate);
- sign-extension versus zero-extension of the immediate;
- masking of the register shift amount to five bits;
- the sign fill of the arithmetic shift.

// File: rtl/int_exec_pkg.sv
package int_exec_pkg;

  localparam int OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ADD_T   = 5'd0,
    OP_ADD_W   = 5'd1,
    OP_SUB_T   = 5'd2,
    OP_SUB_W   = 5'd3,
    OP_ADDI_T  = 5'd4,
    OP_ADDI_W  = 5'd5,
    OP_AND     = 5'd6,
    OP_OR      = 5'd7,
    OP_XOR     = 5'd8,
    OP_NOR     = 5'd9,
    OP_ANDI    = 5'd10,
    OP_ORI     = 5'd11,
    OP_XORI    = 5'd12,
    OP_SHL_R   = 5'd13,
    OP_SHR_R   = 5'd14,
    OP_SAR_R   = 5'd15,
    OP_SHL_I   = 5'd16,
    OP_SHR_I   = 5'd17,
    OP_SAR_I   = 5'd18,
    OP_UPPER   = 5'd19
  } aluOp_e;

  localparam logic [OP_W-1:0] LAST_LEGAL_OP = 5'd19;

  typedef enum logic [1:0] {
    RES_ARITH,
    RES_LOGIC,
    RES_SHIFT,
    RES_UPPER
  } resSel_e;

  typedef enum logic [1:0] {
    LOG_AND,
    LOG_OR,
    LOG_XOR,
    LOG_NOR
  } logicFn_e;

  // Strobes handed from the decoder to the datapath
  typedef struct packed {
    logic     legal;
    logic     useImm;
    logic     immSext;
    logic     subtract;
    logic     trapEn;
    logicFn_e logicFn;
    logic     shLeft;
    logic     shArith;
    logic     shAmtReg;
    resSel_e  resSel;
  } aluStrobe_t;

endpackage

// File: rtl/int_exec_ctrl.sv
module int_exec_ctrl
  import int_exec_pkg::*;
(
  input  logic [OP_W-1:0] opSel,
  output aluStrobe_t      strobe
);

  always_comb begin
    strobe = '0;
    strobe.logicFn = LOG_AND;
    strobe.resSel  = RES_ARITH;
    case (opSel)
      OP_ADD_T: begin
        strobe.legal  = 1'b1;
        strobe.trapEn = 1'b1;
      end
      OP_ADD_W: strobe.legal = 1'b1;
      OP_SUB_T: begin
        strobe.legal    = 1'b1;
        strobe.subtract = 1'b1;
        strobe.trapEn   = 1'b1;
      end
      OP_SUB_W: begin
        strobe.legal    = 1'b1;
        strobe.subtract = 1'b1;
      end
      OP_ADDI_T: begin
        strobe.legal   = 1'b1;
        strobe.useImm  = 1'b1;
        strobe.immSext = 1'b1;
        strobe.trapEn  = 1'b1;
      end
      OP_ADDI_W: begin
        strobe.legal   = 1'b1;
        strobe.useImm  = 1'b1;
        strobe.immSext = 1'b1;
      end
      OP_AND, OP_OR, OP_XOR, OP_NOR: begin
        strobe.legal   = 1'b1;
        strobe.resSel  = RES_LOGIC;
        strobe.logicFn = logicFn_e'(opSel - OP_AND);
      end
      OP_ANDI, OP_ORI, OP_XORI: begin
        strobe.legal   = 1'b1;
        strobe.useImm  = 1'b1;
        strobe.resSel  = RES_LOGIC;
        strobe.logicFn = logicFn_e'(opSel - OP_ANDI);
      end
      OP_SHL_R, OP_SHR_R, OP_SAR_R: begin
        strobe.legal    = 1'b1;
        strobe.resSel   = RES_SHIFT;
        strobe.shAmtReg = 1'b1;
        strobe.shLeft   = (opSel == OP_SHL_R);
        strobe.shArith  = (opSel == OP_SAR_R);
      end
      OP_SHL_I, OP_SHR_I, OP_SAR_I: begin
        strobe.legal   = 1'b1;
        strobe.resSel  = RES_SHIFT;
        strobe.shLeft  = (opSel == OP_SHL_I);
        strobe.shArith = (opSel == OP_SAR_I);
      end
      OP_UPPER: begin
        strobe.legal  = 1'b1;
        strobe.resSel = RES_UPPER;
      end
      default: strobe = strobe;
    endcase
  end

endmodule

// File: rtl/int_exec_shifter.sv
module int_exec_shifter #(
  parameter int DATA_W = 32,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] shIn,
  input  logic [SH_W-1:0]   shAmt,
  input  logic              shLeft,
  input  logic              shArith,
  output logic [DATA_W-1:0] shOut
);

  logic [DATA_W-1:0] revIn;
  logic [DATA_W-1:0] revOut;
  logic [DATA_W-1:0] stage [SH_W+1];
  logic              fillBit;

  // Left shifts reuse the right-shift network on bit-reversed data
  generate
    for (genvar i = 0; i < DATA_W; i++) begin : g_rev
      assign revIn[i]  = shIn[DATA_W-1-i];
      assign revOut[i] = stage[SH_W][DATA_W-1-i];
    end
  endgenerate

  assign fillBit  = shArith & ~shLeft & shIn[DATA_W-1];
  assign stage[0] = shLeft ? revIn : shIn;

  generate
    for (genvar k = 0; k < SH_W; k++) begin : g_stage
      localparam int STEP = 1 << k;
      assign stage[k+1] = shAmt[k]
        ? {{STEP{fillBit}}, stage[k][DATA_W-1:STEP]}
        : stage[k];
    end
  endgenerate

  assign shOut = shLeft ? revOut : stage[SH_W];

endmodule

// File: rtl/int_exec_datapath.sv
module int_exec_datapath
  import int_exec_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  aluStrobe_t        strobe,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  input  logic [IMM_W-1:0]  imm16,
  input  logic [SH_W-1:0]   shamt,
  output logic [DATA_W-1:0] result,
  output logic              wrEn,
  output logic              ovfTrap
);

  logic [DATA_W-1:0] immExt;
  logic [DATA_W-1:0] operandB;
  logic [DATA_W-1:0] addend;
  logic [DATA_W-1:0] sumVal;
  logic              sumOvf;
  logic [DATA_W-1:0] logicVal;
  logic [DATA_W-1:0] shiftVal;
  logic [DATA_W-1:0] upperVal;
  logic [SH_W-1:0]   shAmtSel;

  assign immExt   = strobe.immSext
    ? {{(DATA_W-IMM_W){imm16[IMM_W-1]}}, imm16}
    : {{(DATA_W-IMM_W){1'b0}}, imm16};
  assign operandB = strobe.useImm ? immExt : srcB;

  // Subtract as srcA + ~operandB + 1
  assign addend = strobe.subtract ? ~operandB : operandB;
  assign sumVal = srcA + addend + {{(DATA_W-1){1'b0}}, strobe.subtract};
  assign sumOvf = (srcA[DATA_W-1] == addend[DATA_W-1]) &&
                  (sumVal[DATA_W-1] != srcA[DATA_W-1]);

  always_comb begin
    case (strobe.logicFn)
      LOG_AND: logicVal = srcA & operandB;
      LOG_OR:  logicVal = srcA | operandB;
      LOG_XOR: logicVal = srcA ^ operandB;
      default: logicVal = ~(srcA | operandB);
    endcase
  end

  assign shAmtSel = strobe.shAmtReg ? srcA[SH_W-1:0] : shamt;

  int_exec_shifter #(.DATA_W(DATA_W)) u_shifter (
    .shIn    (srcB),
    .shAmt   (shAmtSel),
    .shLeft  (strobe.shLeft),
    .shArith (strobe.shArith),
    .shOut   (shiftVal)
  );

  assign upperVal = {imm16, {(DATA_W-IMM_W){1'b0}}};

  always_comb begin
    if (!strobe.legal) begin
      result = '0;
    end else begin
      case (strobe.resSel)
        RES_ARITH: result = sumVal;
        RES_LOGIC: result = logicVal;
        RES_SHIFT: result = shiftVal;
        default:   result = upperVal;
      endcase
    end
  end

  assign ovfTrap = strobe.legal & strobe.trapEn & sumOvf;
  assign wrEn    = strobe.legal & ~ovfTrap;

endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
  import int_exec_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  logic [OP_W-1:0]   opSel,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  input  logic [IMM_W-1:0]  imm16,
  input  logic [SH_W-1:0]   shamt,
  output logic [DATA_W-1:0] result,
  output logic              wrEn,
  output logic              ovfTrap
);

  aluStrobe_t strobe;

  int_exec_ctrl u_ctrl (
    .opSel  (opSel),
    .strobe (strobe)
  );

  int_exec_datapath #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_dp (
    .strobe  (strobe),
    .srcA    (srcA),
    .srcB    (srcB),
    .imm16   (imm16),
    .shamt   (shamt),
    .result  (result),
    .wrEn    (wrEn),
    .ovfTrap (ovfTrap)
  );

endmodule

// File: rtl/int_exec_unit_chk.sv
module int_exec_unit_chk
  import int_exec_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input logic [OP_W-1:0]   opSel,
  input logic [DATA_W-1:0] srcA,
  input logic [IMM_W-1:0]  imm16,
  input logic [DATA_W-1:0] result,
  input logic              wrEn,
  input logic              ovfTrap
);

  logic isTrapOp;
  assign isTrapOp = (opSel == OP_ADD_T) || (opSel == OP_SUB_T) || (opSel == OP_ADDI_T);

  always_comb begin
    if (!$isunknown({opSel, srcA, imm16, result, wrEn, ovfTrap})) begin
      // R1
      trap_blocks_write_chk: assert (!(ovfTrap && wrEn));
      // R3
      only_trap_codes_chk: assert (!(ovfTrap && !isTrapOp));
      // R2
      legal_writes_chk: assert (!((opSel <= LAST_LEGAL_OP) && !ovfTrap && !wrEn));
      // R10
      upper_layout_chk: assert (!((opSel == OP_UPPER) &&
        (result != {imm16, {(DATA_W-IMM_W){1'b0}}})));
      // R5
      andi_upper_zero_chk: assert (!((opSel == OP_ANDI) &&
        (result[DATA_W-1:IMM_W] != '0)));
      // R11
      unused_silent_chk: assert (!((opSel > LAST_LEGAL_OP) &&
        (wrEn || ovfTrap || (result != '0))));
    end
  end

endmodule

bind int_exec_unit int_exec_unit_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_chk (
  .opSel   (opSel),
  .srcA    (srcA),
  .imm16   (imm16),
  .result  (result),
  .wrEn    (wrEn),
  .ovfTrap (ovfTrap)
);

// File: tb/tb_int_exec_unit.sv
`timescale 1ns/1ps
module tb_int_exec_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  opSel;
  logic [31:0] srcA, srcB;
  logic [15:0] imm16;
  logic [4:0]  shamt;
  logic [31:0] result;
  logic        wrEn, ovfTrap;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  int_exec_unit dut (
    .opSel(opSel), .srcA(srcA), .srcB(srcB), .imm16(imm16), .shamt(shamt),
    .result(result), .wrEn(wrEn), .ovfTrap(ovfTrap)
  );

  typedef struct packed {
    logic [4:0]  op;
    logic [31:0] a;
    logic [31:0] b;
    logic [15:0] imm;
    logic [4:0]  sh;
    logic [31:0] expRes;
    logic        expWe;
    logic        expOvf;
  } vec_t;

  localparam int NVEC = 14;
  localparam vec_t VECS [NVEC] = '{
    '{5'd0,  32'h7FFFFFFF, 32'h00000001, 16'h0, 5'd0, 32'h0,        1'b0, 1'b1}, // R1
    '{5'd2,  32'h00000000, 32'h80000000, 16'h0, 5'd0, 32'h0,        1'b0, 1'b1}, // R1
    '{5'd2,  32'h80000000, 32'h00000001, 16'h0, 5'd0, 32'h0,        1'b0, 1'b1}, // R1
    '{5'd4,  32'h80000000, 32'h0,        16'h8000, 5'd0, 32'h0,     1'b0, 1'b1}, // R1 R4
    '{5'd0,  32'h7FFFFFFE, 32'h00000001, 16'h0, 5'd0, 32'h7FFFFFFF, 1'b1, 1'b0}, // R2
    '{5'd1,  32'h7FFFFFFF, 32'h00000001, 16'h0, 5'd0, 32'h80000000, 1'b1, 1'b0}, // R3
    '{5'd3,  32'h00000000, 32'h00000001, 16'h0, 5'd0, 32'hFFFFFFFF, 1'b1, 1'b0}, // R3
    '{5'd5,  32'h00000010, 32'h0,        16'hFFFF, 5'd0, 32'h0000000F, 1'b1, 1'b0}, // R4
    '{5'd10, 32'hFFFFFFFF, 32'h0,        16'h8000, 5'd0, 32'h00008000, 1'b1, 1'b0}, // R5
    '{5'd9,  32'h00000000, 32'h00000000, 16'h0, 5'd0, 32'hFFFFFFFF, 1'b1, 1'b0}, // R6
    '{5'd15, 32'h00000023, 32'h80000000, 16'h0, 5'd0, 32'hF0000000, 1'b1, 1'b0}, // R7 R9
    '{5'd16, 32'h0,        32'h80000001, 16'h0, 5'd1, 32'h00000002, 1'b1, 1'b0}, // R8 R9
    '{5'd17, 32'h0,        32'h80000000, 16'h0, 5'd31, 32'h00000001, 1'b1, 1'b0}, // R9
    '{5'd19, 32'hFFFFFFFF, 32'hFFFFFFFF, 16'h1234, 5'd7, 32'h12340000, 1'b1, 1'b0} // R10
  };

  function automatic string reqOf(input logic [4:0] op);
    case (op)
      5'd0, 5'd2, 5'd4:   return "R1/R2";
      5'd1, 5'd3, 5'd5:   return "R3";
      5'd6, 5'd7, 5'd8, 5'd9: return "R6";
      5'd10, 5'd11, 5'd12: return "R5";
      5'd13, 5'd14, 5'd15: return "R7";
      5'd16, 5'd17, 5'd18: return "R8";
      5'd19:               return "R10";
      default:             return "R11";
    endcase
  endfunction

  // Reference model written from the requirements using wide signed arithmetic
  function automatic logic [33:0] refModel(input logic [4:0] op, input logic [31:0] a,
      input logic [31:0] b, input logic [15:0] imm, input logic [4:0] sh);
    longint sa, sb, si, s;
    logic [31:0] r;
    logic we, ov;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    si = longint'($signed(imm));
    we = 1'b1; ov = 1'b0; r = 32'h0; s = 0;
    case (op)
      5'd0, 5'd1: s = sa + sb;
      5'd2, 5'd3: s = sa - sb;
      5'd4, 5'd5: s = sa + si;
      default: s = 0;
    endcase
    case (op)
      5'd0, 5'd1, 5'd2, 5'd3, 5'd4, 5'd5: begin
        r = s[31:0];
        if ((op == 5'd0 || op == 5'd2 || op == 5'd4) &&
            (s > 64'sd2147483647 || s < -64'sd2147483648)) begin
          ov = 1'b1; we = 1'b0;
        end
      end
      5'd6:  r = a & b;
      5'd7:  r = a | b;
      5'd8:  r = a ^ b;
      5'd9:  r = ~(a | b);
      5'd10: r = a & {16'h0, imm};
      5'd11: r = a | {16'h0, imm};
      5'd12: r = a ^ {16'h0, imm};
      5'd13: r = b << a[4:0];
      5'd14: r = b >> a[4:0];
      5'd15: r = $unsigned($signed(b) >>> a[4:0]);
      5'd16: r = b << sh;
      5'd17: r = b >> sh;
      5'd18: r = $unsigned($signed(b) >>> sh);
      5'd19: r = {imm, 16'h0};
      default: begin r = 32'h0; we = 1'b0; end
    endcase
    return {r, we, ov};
  endfunction

  task automatic apply(input logic [4:0] op, input logic [31:0] a, input logic [31:0] b,
      input logic [15:0] imm, input logic [4:0] sh);
    @(negedge clk);
    opSel = op; srcA = a; srcB = b; imm16 = imm; shamt = sh;
    #2;
  endtask

  task automatic chk(input string req, input logic [31:0] er, input logic ewe,
      input logic eov);
    checks++;
    if (wrEn !== ewe || ovfTrap !== eov || (!eov && result !== er)) begin
      errors++;
      $display("FAIL %s op=%0d: result=%h wrEn=%b ovfTrap=%b, expected result=%h wrEn=%b ovfTrap=%b",
               req, opSel, result, wrEn, ovfTrap, er, ewe, eov);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [33:0] exp;
    opSel = 5'd31; srcA = '0; srcB = '0; imm16 = '0; shamt = '0;
    repeat (3) @(posedge clk);
    #2;
    chk("R11 reset idle", 32'h0, 1'b0, 1'b0);
    rst = 1'b0;

    // Table of hand-computed vectors
    for (int i = 0; i < NVEC; i++) begin
      apply(VECS[i].op, VECS[i].a, VECS[i].b, VECS[i].imm, VECS[i].sh);
      chk($sformatf("table %0d %s", i, reqOf(VECS[i].op)),
          VECS[i].expRes, VECS[i].expWe, VECS[i].expOvf);
    end

    // Directed corner cases
    apply(5'd4, 32'h7FFFFFFF, 32'h0, 16'h0001, 5'd0);
    chk("R1 addi +1 at max", 32'h0, 1'b0, 1'b1);
    apply(5'd4, 32'h00000000, 32'h0, 16'h7FFF, 5'd0);
    chk("R4 addi +7FFF", 32'h00007FFF, 1'b1, 1'b0);
    apply(5'd2, 32'hFFFFFFFF, 32'h80000000, 16'h0, 5'd0);
    chk("R2 sub -1 minus min no ovf", 32'h7FFFFFFF, 1'b1, 1'b0);
    apply(5'd3, 32'h00000000, 32'h80000000, 16'h0, 5'd0);
    chk("R3 wrap sub of min", 32'h80000000, 1'b1, 1'b0);
    apply(5'd11, 32'h12340000, 32'h0, 16'hFFFF, 5'd0);
    chk("R5 ori zero-extend", 32'h1234FFFF, 1'b1, 1'b0);
    apply(5'd14, 32'hFFFFFFE4, 32'h80000000, 16'h0, 5'd0);
    chk("R7 srlv masks amount to 4", 32'h08000000, 1'b1, 1'b0);
    apply(5'd18, 32'h0, 32'h40000000, 16'h0, 5'd0);
    chk("R8 sra by zero", 32'h40000000, 1'b1, 1'b0);
    apply(5'd18, 32'h0, 32'h80000000, 16'h0, 5'd31);
    chk("R9 sra fill", 32'hFFFFFFFF, 1'b1, 1'b0);
    apply(5'd13, 32'h00000004, 32'hF0000001, 16'h0, 5'd0);
    chk("R9 sllv loses bits no trap", 32'h00000010, 1'b1, 1'b0);
    apply(5'd20, 32'hFFFFFFFF, 32'hFFFFFFFF, 16'hFFFF, 5'd31);
    chk("R11 unused code 20", 32'h0, 1'b0, 1'b0);

    // Reference sweep over every code
    for (int op = 0; op < 32; op++) begin
      for (int n = 0; n < 60; n++) begin
        logic [31:0] ra, rb;
        ra = $urandom;
        rb = $urandom;
        if (n == 0) begin ra = 32'h7FFFFFFF; rb = 32'h7FFFFFFF; end
        if (n == 1) begin ra = 32'h80000000; rb = 32'h80000000; end
        apply(5'(op), ra, rb, 16'($urandom), 5'($urandom));
        exp = refModel(5'(op), ra, rb, imm16, shamt);
        chk($sformatf("sweep %s", reqOf(5'(op))), exp[33:2], exp[1], exp[0]);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule